// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a 32-pin general-purpose I/O bank on a simple memory-mapped register bus with address, write enable, write data and combinational read data. Each pin is either a plain output or an interrupt source. An interrupt source watches for one of four conditions: a rising edge, a falling edge, a high level or a low level. A detected event is latched in a per-pin flag. A per-pin mask keeps that flag off the single summary interrupt line that goes to the parent interrupt controller.

Two pattern registers do double duty. For a pin that is not an interrupt source, the polarity pattern is the value driven on its output. For an interrupt source, one pattern register picks edge or level and the other picks the active sense. The hardware has no mode that detects both edges at once. Software gets that behaviour by flipping the polarity bit after each event it services. Every writable register has a set alias at base+0x4 and a clear alias at base+0x8, so single bits change without a read-modify-write.

Register map (byte offsets on `bus_addr`):

| Offset | Register | Access |
|---|---|---|
| 0x00 | synchronised pin levels | read only |
| 0x10 | interrupt enable | read/write |
| 0x20 | interrupt mask | read/write |
| 0x30 | mode select (1 = edge, 0 = level) | read/write |
| 0x40 | polarity / output data | read/write |
| 0x50 | event flags | read; clear through 0x58 only |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the enable, mode, polarity and flag registers read 0, the mask register reads 0xFFFFFFFF, `pin_out` is 0 and `irq_out` is 0.
- R2: A write to a register's base offset replaces the whole register. A write to base+0x4 sets the bits that are 1 in the data, and a write to base+0x8 clears the bits that are 1 in the data. Bits that are 0 in alias data are left unchanged.
- R3: A pin whose enable bit (offset 0x10) is 0 drives its polarity bit (offset 0x40) on `pin_out`. A pin whose enable bit is 1 drives 0.
- R4: With enable=1, mode=1 and polarity=1, a pin's flag sets on the third rising clock edge after a 0-to-1 input change. A 1-to-0 change sets nothing.
- R5: With enable=1, mode=1 and polarity=0, a pin's flag sets on a 1-to-0 input change. A 0-to-1 change sets nothing.
- R6: With enable=1, mode=0 and polarity=1, the flag sets while the synchronised pin is high. A clear has no effect while the level persists. Once the pin is low, a clear leaves the flag at 0.
- R7: With enable=1, mode=0 and polarity=0, the flag sets while the synchronised pin is low. The flag sets on the second rising edge after enable is written if the pin is already low.
- R8: A write of 1 bits to offset 0x58 clears those flags and leaves the other flags unchanged. Writes to 0x50 and 0x54 leave the flags unchanged.
- R9: A pin whose mask bit (offset 0x20) is 1 still latches its flag but does not drive `irq_out`. Clearing the mask bit raises `irq_out` one clock after the mask write.
- R10: `irq_out` equals the OR over all pins of (flag AND NOT mask) as it stood one clock earlier.
- R11: Offset 0x00 returns `pin_in` two clocks after it changes, and writes to it have no effect.
- R12: A pin whose enable bit is 0 never sets its flag, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data for pins not used as interrupt sources |
| irq_out | output | 1 | Summary interrupt to the parent controller |

## Verification
The hardest case to reach is a clear that lands while a level condition is still present. The flag must stay at 1 through that clear. It must also stay at 1 while the mask hides it from `irq_out`. The bench reaches this state by holding a high-level source with its mask bit set and issuing the clear while the pin stays high. It then unmasks the pin and watches `irq_out` rise exactly one clock later. After that it drops the pin and clears again, and the flag must stay at 0. Selective clears of two pending flags and ignored writes to the flag base and set offsets complete the picture.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h50;

  localparam logic [ADDR_W-1:0] ALIAS_SET = 8'h04;
  localparam logic [ADDR_W-1:0] ALIAS_CLR = 8'h08;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_WRITE,
    ACC_SET,
    ACC_CLR
  } acc_e;

  function automatic acc_e decode_acc(input logic we,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base);
    acc_e r;
    r = ACC_NONE;
    if (we) begin
      if (addr == base)                  r = ACC_WRITE;
      else if (addr == base + ALIAS_SET) r = ACC_SET;
      else if (addr == base + ALIAS_CLR) r = ACC_CLR;
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_irq_ctrlreg.sv
module gpio_irq_ctrlreg
  import gpio_irq_pkg::*;
#(
  parameter int               W       = 32,
  parameter logic [ADDR_W-1:0] BASE   = OFS_IEN,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);

  acc_e         acc;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    acc  = decode_acc(we, addr, BASE);
    q_en = (acc != ACC_NONE);
    case (acc)
      ACC_WRITE: q_d = wdata;
      ACC_SET:   q_d = q | wdata;
      ACC_CLR:   q_d = q & ~wdata;
      default:   q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= pin_in;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flag,
  output logic         irq_out
);

  logic [W-1:0] det;
  logic [W-1:0] flag_d;
  logic         irq_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit_edge;
    logic hit_lvl;
    always_comb begin
      hit_edge = pol[i] ? (lvl[i] & ~lvl_prev[i]) : (~lvl[i] & lvl_prev[i]);
      hit_lvl  = pol[i] ? lvl[i] : ~lvl[i];
      det[i]   = ien[i] & (edge_mode[i] ? hit_edge : hit_lvl);
    end
  end

  // a new detection outranks a clear in the same cycle
  always_comb begin
    flag_d = (flag & ~clr_vec) | det;
    irq_d  = |(flag & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= '0;
      irq_out <= 1'b0;
    end else begin
      flag    <= flag_d;
      irq_out <= irq_d;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic              irq_out
);

  localparam logic [PIN_W-1:0] ALL_ONES = '1;

  logic [PIN_W-1:0] ien_q, mask_q, mode_q, pol_q;
  logic [PIN_W-1:0] lvl, lvl_prev, flag_q, clr_vec;

  gpio_irq_ctrlreg #(.W(PIN_W), .BASE(OFS_IEN), .RST_VAL('0)) u_ien (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(ien_q));
  gpio_irq_ctrlreg #(.W(PIN_W), .BASE(OFS_MASK), .RST_VAL(ALL_ONES)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(mask_q));
  gpio_irq_ctrlreg #(.W(PIN_W), .BASE(OFS_MODE), .RST_VAL('0)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(mode_q));
  gpio_irq_ctrlreg #(.W(PIN_W), .BASE(OFS_POL), .RST_VAL('0)) u_pol (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .q(pol_q));

  gpio_irq_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(lvl), .lvl_prev(lvl_prev));

  always_comb begin
    clr_vec = (bus_we && bus_addr == OFS_FLAG + ALIAS_CLR) ? bus_wdata : '0;
  end

  gpio_irq_detect #(.W(PIN_W)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .lvl_prev(lvl_prev), .ien(ien_q),
    .edge_mode(mode_q), .pol(pol_q), .mask(mask_q), .clr_vec(clr_vec),
    .flag(flag_q), .irq_out(irq_out));

  always_comb begin
    pin_out = pol_q & ~ien_q;
    case (bus_addr)
      OFS_LEVEL: bus_rdata = lvl;
      OFS_IEN:   bus_rdata = ien_q;
      OFS_MASK:  bus_rdata = mask_q;
      OFS_MODE:  bus_rdata = mode_q;
      OFS_POL:   bus_rdata = pol_q;
      OFS_FLAG:  bus_rdata = flag_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PIN_W-1:0]  ien,
  input logic [PIN_W-1:0]  mask,
  input logic [PIN_W-1:0]  flag,
  input logic [PIN_W-1:0]  pin_out,
  input logic              irq_out
);

  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == (|($past(flag) & ~$past(mask)))); // R10

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |=> !irq_out); // R9

  AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(ien)) == '0)); // R12

  AST_FLAG_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag) & ~flag) == '0) ||
              ($past(bus_we) && $past(bus_addr) == OFS_FLAG + ALIAS_CLR))); // R8

  AST_SOURCE_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ien) == '0); // R3

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .ien(ien_q),
  .mask(mask_q), .flag(flag_q), .pin_out(pin_out), .irq_out(irq_out));

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic        irq_out;

  int n_chk;
  int n_bad;
  bit done;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq_out(irq_out));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h10, v); check("R1 enable", v, 32'h0);
    rd(8'h20, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R1 mode", v, 32'h0);
    rd(8'h40, v); check("R1 polarity", v, 32'h0);
    rd(8'h50, v); check("R1 flags", v, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(8'h40, 32'h0000_00F0); rd(8'h40, v); check("R2 base write", v, 32'h0000_00F0);
    wr(8'h44, 32'h0000_0003); rd(8'h40, v); check("R2 set alias", v, 32'h0000_00F3);
    wr(8'h48, 32'h0000_0030); rd(8'h40, v); check("R2 clear alias", v, 32'h0000_00C3);
    check("R3 output follows polarity", pin_out, 32'h0000_00C3);
    wr(8'h14, 32'h0000_0001);
    check("R3 enabled pin not driven", pin_out, 32'h0000_00C2);
    wr(8'h18, 32'h0000_0001);
    wr(8'h40, 32'h0);
    wr(8'h20, 32'h0000_FFFF); rd(8'h20, v); check("R2 mask base write", v, 32'h0000_FFFF);
    wr(8'h24, 32'hFFFF_0000); rd(8'h20, v); check("R2 mask set alias", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_level_reg();
    logic [31:0] v;
    pin_in = 32'hA5A5_0F01;
    tick(2);
    rd(8'h00, v); check("R11 level read", v, 32'hA5A5_0F01);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); check("R11 write ignored", v, 32'hA5A5_0F01);
    pin_in = 32'h0;
    tick(3);
    rd(8'h50, v); check("R12 disabled pins no flag", v, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(8'h28, 32'h8); wr(8'h34, 32'h8); wr(8'h44, 32'h8); wr(8'h14, 32'h8);
    check("R3 source pin output 0", pin_out, 32'h0);
    pin_in[3] = 1'b1;
    tick(3);
    rd(8'h50, v); check("R4 rising flag", v, 32'h8);
    check("R10 irq one clock after flag", {31'h0, irq_out}, 32'h0);
    tick(1);
    check("R10 irq raised", {31'h0, irq_out}, 32'h1);
    wr(8'h58, 32'h8);
    rd(8'h50, v); check("R8 flag cleared", v, 32'h0);
    tick(1);
    check("R10 irq dropped", {31'h0, irq_out}, 32'h0);
    pin_in[3] = 1'b0;
    tick(4);
    rd(8'h50, v); check("R4 falling ignored", v, 32'h0);
    wr(8'h18, 32'h8); wr(8'h38, 32'h8); wr(8'h48, 32'h8); wr(8'h24, 32'h8);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(8'h34, 32'h20); wr(8'h14, 32'h20);
    pin_in[5] = 1'b1;
    tick(4);
    rd(8'h50, v); check("R5 rising ignored", v, 32'h0);
    pin_in[5] = 1'b0;
    tick(3);
    rd(8'h50, v); check("R5 falling flag", v, 32'h20);
    check("R9 masked pin no irq", {31'h0, irq_out}, 32'h0);
    wr(8'h58, 32'h20);
    wr(8'h18, 32'h20); wr(8'h38, 32'h20);
  endtask

  task automatic t_level_hi();
    logic [31:0] v;
    wr(8'h44, 32'h80); wr(8'h14, 32'h80);
    pin_in[7] = 1'b1;
    tick(3);
    rd(8'h50, v); check("R6 high level flag", v, 32'h80);
    tick(2);
    check("R9 masked flag keeps irq low", {31'h0, irq_out}, 32'h0);
    wr(8'h58, 32'h80);
    rd(8'h50, v); check("R6 clear while level held", v, 32'h80);
    wr(8'h28, 32'h80);
    check("R9 irq not yet raised", {31'h0, irq_out}, 32'h0);
    tick(1);
    check("R9 unmask raises irq", {31'h0, irq_out}, 32'h1);
    pin_in[7] = 1'b0;
    tick(3);
    wr(8'h58, 32'h80);
    tick(3);
    rd(8'h50, v); check("R6 clear after level gone", v, 32'h0);
    check("R6 irq low after clear", {31'h0, irq_out}, 32'h0);
    wr(8'h18, 32'h80); wr(8'h48, 32'h80); wr(8'h24, 32'h80);
  endtask

  task automatic t_level_lo();
    logic [31:0] v;
    wr(8'h14, 32'h200);
    rd(8'h50, v); check("R7 not yet latched", v, 32'h0);
    tick(1);
    rd(8'h50, v); check("R7 low level flag", v, 32'h200);
    pin_in[9] = 1'b1;
    tick(3);
    wr(8'h58, 32'h200);
    rd(8'h50, v); check("R7 clear once high", v, 32'h0);
    wr(8'h18, 32'h200);
  endtask

  task automatic t_clear_sel();
    logic [31:0] v;
    wr(8'h34, 32'hC00); wr(8'h44, 32'hC00); wr(8'h14, 32'hC00);
    pin_in[10] = 1'b1;
    pin_in[11] = 1'b1;
    tick(3);
    rd(8'h50, v); check("R8 two flags", v, 32'hC00);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h50, v); check("R8 base/set writes ignored", v, 32'hC00);
    wr(8'h58, 32'h400);
    rd(8'h50, v); check("R8 selective clear", v, 32'h800);
    wr(8'h58, 32'h800);
    rd(8'h50, v); check("R8 second clear", v, 32'h0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0; pin_in = 32'h0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_alias();
    t_level_reg();
    t_rise();
    t_fall();
    t_level_hi();
    t_level_lo();
    t_clear_sel();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule